// File: doc/BRIEF.md
# Time-Slotted Shared RAM Arbiter

This block lets three requesters share one single-port data RAM of 512 words by 32 bits: a microprocessor, a compute engine and an SPI slave. The RAM side runs at four times the system rate. Each base period is therefore split into four fixed access slots. The processor owns two of the slots and has two independent request lanes, one per slot. The engine and the SPI port own one slot each. The plan is static. A requester that does not ask for its slot leaves the slot empty, and no other requester is given that slot, so every requester gets a guaranteed bandwidth.

The block runs on the fast clock only. A free-running 2-bit slot counter derives the base clock output, so base edges and slot 0 stay phase-aligned. Each requester drives its request, write enable, address and write data from the base clock and holds them for one whole base period. The block routes each lane onto the RAM port during that lane's slot. For a read, the RAM must present the word combinationally within the same slot. All acknowledges and read data become visible together at the next base edge. They are then held for one full base period, so the requester samples them on the base edge that follows.

Top module: `shared_ram_slot_arbiter`

## Requirements
- R1: `base_clk_o` is high for two fast cycles (slots 0 and 1) and low for two (slots 2 and 3), which makes a base period of four fast cycles. Slot 0 is the first fast cycle after reset.
- R2: Slot order is fixed. Slot 0 carries processor lane A, slot 1 the engine, slot 2 processor lane B and slot 3 the SPI lane. When the owning lane requests, `ram_en_o` is 1 and `ram_addr_o` and `ram_we_o` equal that lane's address and write enable.
- R3: In a slot whose owner does not request, `ram_en_o` and `ram_we_o` are 0. The slot is never given to another lane. The number of RAM accesses in a period equals the number of requesting lanes.
- R4: A lane that requests in base period N has its acknowledge at 1 for the whole of period N+1. A lane that does not request has its acknowledge at 0 for the whole of period N+1. Acknowledges change only at base edges.
- R5: A read in period N shows up on that lane's read data for the whole of period N+1. It returns the RAM word as it stands in that lane's slot, so a write by an earlier slot of the same period is already visible.
- R6: A write, or an idle period, leaves that lane's read data unchanged.
- R7: When two lanes write the same address in one period, the RAM keeps the value written in the later slot.
- R8: While `rst_ni` is low, all acknowledges and all read data outputs are 0 and `base_clk_o` is 1.
- R9: The two processor lanes are independent. Each has its own acknowledge and read data, and one lane may request while the other is idle.
- R10: During a granted write slot, `ram_wdata_o` equals the write data of the owning lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four per base period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_clk_o | output | 1 | Base clock derived from the slot counter |
| cpu0_req_i | input | 1 | Processor lane A request (slot 0) |
| cpu0_we_i | input | 1 | Processor lane A write enable |
| cpu0_addr_i | input | 9 | Processor lane A word address |
| cpu0_wdata_i | input | 32 | Processor lane A write data |
| cpu0_rdata_o | output | 32 | Processor lane A read data |
| cpu0_ack_o | output | 1 | Processor lane A acknowledge |
| cpu1_req_i | input | 1 | Processor lane B request (slot 2) |
| cpu1_we_i | input | 1 | Processor lane B write enable |
| cpu1_addr_i | input | 9 | Processor lane B word address |
| cpu1_wdata_i | input | 32 | Processor lane B write data |
| cpu1_rdata_o | output | 32 | Processor lane B read data |
| cpu1_ack_o | output | 1 | Processor lane B acknowledge |
| ce_req_i | input | 1 | Engine request (slot 1) |
| ce_we_i | input | 1 | Engine write enable |
| ce_addr_i | input | 9 | Engine word address |
| ce_wdata_i | input | 32 | Engine write data |
| ce_rdata_o | output | 32 | Engine read data |
| ce_ack_o | output | 1 | Engine acknowledge |
| spi_req_i | input | 1 | SPI request (slot 3) |
| spi_we_i | input | 1 | SPI write enable |
| spi_addr_i | input | 9 | SPI word address |
| spi_wdata_i | input | 32 | SPI write data |
| spi_rdata_o | output | 32 | SPI read data |
| spi_ack_o | output | 1 | SPI acknowledge |
| ram_en_o | output | 1 | RAM access enable for the current slot |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 9 | RAM word address |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, valid within the slot |

## Verification
The bench builds the block with its default parameters: 512 words and 32-bit data. It attaches a behavioural RAM of that size. Most random traffic is confined to addresses 0 to 7 plus the top word 511. This keeps same-address collisions between slots frequent, so both the later-slot-wins rule and same-period read-after-write forwarding are exercised often. The address extremes 0 and 511 also reach the full 9-bit address path.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  // slot index doubles as lane index
  typedef enum logic [SLOT_W-1:0] {
    SLOT_CPU_A = 2'd0,
    SLOT_ENG   = 2'd1,
    SLOT_CPU_B = 2'd2,
    SLOT_SPI   = 2'd3
  } slot_e;
endpackage

// File: rtl/ram_slot_timer.sv
module ram_slot_timer
  import ram_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_e slot_o,
  output logic  last_o,
  output logic  base_clk_o
);
  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o     = slot_e'(cnt_q);
  assign last_o     = (cnt_q == SLOT_W'(NUM_SLOTS - 1));
  // high in the first half of the period, rising edge aligned to slot 0
  assign base_clk_o = ~cnt_q[SLOT_W-1];
endmodule

// File: rtl/ram_slot_mux.sv
module ram_slot_mux
  import ram_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = NUM_SLOTS
) (
  input  slot_e                      slot_i,
  input  logic [N-1:0]               req_i,
  input  logic [N-1:0]               we_i,
  input  logic [N-1:0][ADDR_W-1:0]   addr_i,
  input  logic [N-1:0][DATA_W-1:0]   wdata_i,
  output logic [N-1:0]               grant_o,
  output logic                       en_o,
  output logic                       we_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [DATA_W-1:0]          wdata_o
);
  always_comb begin
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (SLOT_W'(i) == slot_i) grant_o[i] = req_i[i];
    end
  end

  // one-hot AND-OR steering; an empty slot leaves every output at zero
  always_comb begin
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) begin
        we_o    = we_o | we_i[i];
        addr_o  = addr_o | addr_i[i];
        wdata_o = wdata_o | (we_i[i] ? wdata_i[i] : '0);
      end
    end
  end

  assign en_o = |grant_o;
endmodule

// File: rtl/ram_lane_return.sv
module ram_lane_return #(
  parameter int unsigned DATA_W = 32,
  parameter bit          DIRECT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_slot_i,
  input  logic              grant_i,
  input  logic              we_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_hit;

  assign rd_hit = grant_i & ~we_i;

  if (DIRECT) begin : g_direct
    // owner of the final slot: capture and publish on the same edge
    logic unused_own;
    assign unused_own = own_slot_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ack_q   <= 1'b0;
        rdata_q <= '0;
      end else if (last_i) begin
        ack_q <= grant_i;
        if (rd_hit) rdata_q <= ram_rdata_i;
      end
    end
  end else begin : g_staged
    logic              stg_vld_q;
    logic              stg_rd_q;
    logic [DATA_W-1:0] stg_data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_vld_q  <= 1'b0;
        stg_rd_q   <= 1'b0;
        stg_data_q <= '0;
      end else if (own_slot_i) begin
        stg_vld_q <= grant_i;
        stg_rd_q  <= rd_hit;
        if (rd_hit) stg_data_q <= ram_rdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ack_q   <= 1'b0;
        rdata_q <= '0;
      end else if (last_i) begin
        ack_q <= stg_vld_q;
        if (stg_rd_q) rdata_q <= stg_data_q;
      end
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/shared_ram_slot_arbiter.sv
module shared_ram_slot_arbiter
  import ram_arb_pkg::*;
#(
  parameter  int unsigned DEPTH  = 512,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              base_clk_o,
  input  logic              cpu0_req_i,
  input  logic              cpu0_we_i,
  input  logic [ADDR_W-1:0] cpu0_addr_i,
  input  logic [DATA_W-1:0] cpu0_wdata_i,
  output logic [DATA_W-1:0] cpu0_rdata_o,
  output logic              cpu0_ack_o,
  input  logic              cpu1_req_i,
  input  logic              cpu1_we_i,
  input  logic [ADDR_W-1:0] cpu1_addr_i,
  input  logic [DATA_W-1:0] cpu1_wdata_i,
  output logic [DATA_W-1:0] cpu1_rdata_o,
  output logic              cpu1_ack_o,
  input  logic              ce_req_i,
  input  logic              ce_we_i,
  input  logic [ADDR_W-1:0] ce_addr_i,
  input  logic [DATA_W-1:0] ce_wdata_i,
  output logic [DATA_W-1:0] ce_rdata_o,
  output logic              ce_ack_o,
  input  logic              spi_req_i,
  input  logic              spi_we_i,
  input  logic [ADDR_W-1:0] spi_addr_i,
  input  logic [DATA_W-1:0] spi_wdata_i,
  output logic [DATA_W-1:0] spi_rdata_o,
  output logic              spi_ack_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int unsigned N = NUM_SLOTS;

  slot_e                     slot;
  logic                      last;
  logic [N-1:0]              req_v, we_v, grant_v, ack_v;
  logic [N-1:0][ADDR_W-1:0]  addr_v;
  logic [N-1:0][DATA_W-1:0]  wdata_v, rdata_v;

  // lane index equals slot index
  assign req_v[SLOT_CPU_A]   = cpu0_req_i;
  assign we_v[SLOT_CPU_A]    = cpu0_we_i;
  assign addr_v[SLOT_CPU_A]  = cpu0_addr_i;
  assign wdata_v[SLOT_CPU_A] = cpu0_wdata_i;
  assign req_v[SLOT_ENG]     = ce_req_i;
  assign we_v[SLOT_ENG]      = ce_we_i;
  assign addr_v[SLOT_ENG]    = ce_addr_i;
  assign wdata_v[SLOT_ENG]   = ce_wdata_i;
  assign req_v[SLOT_CPU_B]   = cpu1_req_i;
  assign we_v[SLOT_CPU_B]    = cpu1_we_i;
  assign addr_v[SLOT_CPU_B]  = cpu1_addr_i;
  assign wdata_v[SLOT_CPU_B] = cpu1_wdata_i;
  assign req_v[SLOT_SPI]     = spi_req_i;
  assign we_v[SLOT_SPI]      = spi_we_i;
  assign addr_v[SLOT_SPI]    = spi_addr_i;
  assign wdata_v[SLOT_SPI]   = spi_wdata_i;

  ram_slot_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_o     (slot),
    .last_o     (last),
    .base_clk_o (base_clk_o)
  );

  ram_slot_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N      (N)
  ) u_mux (
    .slot_i  (slot),
    .req_i   (req_v),
    .we_i    (we_v),
    .addr_i  (addr_v),
    .wdata_i (wdata_v),
    .grant_o (grant_v),
    .en_o    (ram_en_o),
    .we_o    (ram_we_o),
    .addr_o  (ram_addr_o),
    .wdata_o (ram_wdata_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    ram_lane_return #(
      .DATA_W (DATA_W),
      .DIRECT (i == N - 1)
    ) u_ret (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .own_slot_i  (slot == slot_e'(i)),
      .grant_i     (grant_v[i]),
      .we_i        (we_v[i]),
      .last_i      (last),
      .ram_rdata_i (ram_rdata_i),
      .ack_o       (ack_v[i]),
      .rdata_o     (rdata_v[i])
    );
  end

  assign cpu0_ack_o   = ack_v[SLOT_CPU_A];
  assign cpu0_rdata_o = rdata_v[SLOT_CPU_A];
  assign ce_ack_o     = ack_v[SLOT_ENG];
  assign ce_rdata_o   = rdata_v[SLOT_ENG];
  assign cpu1_ack_o   = ack_v[SLOT_CPU_B];
  assign cpu1_rdata_o = rdata_v[SLOT_CPU_B];
  assign spi_ack_o    = ack_v[SLOT_SPI];
  assign spi_rdata_o  = rdata_v[SLOT_SPI];
endmodule

// File: rtl/ram_slot_checker.sv
module ram_slot_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  base_clk_i,
  input logic                  ram_en_i,
  input logic                  ram_we_i,
  input logic [ADDR_W-1:0]     ram_addr_i,
  input logic [3:0]            req_i,
  input logic [3:0]            we_i,
  input logic [4*ADDR_W-1:0]   addr_i,
  input logic [3:0]            ack_i,
  input logic [4*DATA_W-1:0]   rdata_i
);
  logic [1:0] chk_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_slot <= 2'd0;
    else         chk_slot <= chk_slot + 2'd1;
  end

  AST_BASE_HIGH_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(base_clk_i) |=> base_clk_i ##1 !base_clk_i); // R1
  AST_BASE_LOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(base_clk_i) |=> !base_clk_i ##1 base_clk_i); // R1
  AST_ROUTE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_i |-> ram_addr_i == addr_i[chk_slot*ADDR_W +: ADDR_W]); // R2
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_i |-> req_i[chk_slot]); // R3
  AST_WE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i |-> ram_en_i && we_i[chk_slot]); // R10
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_slot != 2'd0) |-> $stable(ack_i)); // R4
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_slot != 2'd0) |-> $stable(rdata_i)); // R5
endmodule

bind shared_ram_slot_arbiter ram_slot_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .base_clk_i (base_clk_o),
  .ram_en_i   (ram_en_o),
  .ram_we_i   (ram_we_o),
  .ram_addr_i (ram_addr_o),
  .req_i      ({spi_req_i, cpu1_req_i, ce_req_i, cpu0_req_i}),
  .we_i       ({spi_we_i, cpu1_we_i, ce_we_i, cpu0_we_i}),
  .addr_i     ({spi_addr_i, cpu1_addr_i, ce_addr_i, cpu0_addr_i}),
  .ack_i      ({spi_ack_o, cpu1_ack_o, ce_ack_o, cpu0_ack_o}),
  .rdata_i    ({spi_rdata_o, cpu1_rdata_o, ce_rdata_o, cpu0_rdata_o})
);

// File: tb/tb_shared_ram_slot_arbiter.sv
`timescale 1ns/1ps
module tb_shared_ram_slot_arbiter;
  localparam int CLK_PERIOD = 20;
  localparam int DEPTH = 512;
  localparam int DW = 32;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]    b_req, b_we;
  logic [AW-1:0] b_addr [4];
  logic [DW-1:0] b_wdata [4];
  logic [3:0]    o_ack;
  logic [DW-1:0] o_rd [4];
  logic          base_clk, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  logic [DW-1:0] mem [DEPTH];
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;

  shared_ram_slot_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .base_clk_o(base_clk),
    .cpu0_req_i(b_req[0]), .cpu0_we_i(b_we[0]), .cpu0_addr_i(b_addr[0]),
    .cpu0_wdata_i(b_wdata[0]), .cpu0_rdata_o(o_rd[0]), .cpu0_ack_o(o_ack[0]),
    .cpu1_req_i(b_req[2]), .cpu1_we_i(b_we[2]), .cpu1_addr_i(b_addr[2]),
    .cpu1_wdata_i(b_wdata[2]), .cpu1_rdata_o(o_rd[2]), .cpu1_ack_o(o_ack[2]),
    .ce_req_i(b_req[1]), .ce_we_i(b_we[1]), .ce_addr_i(b_addr[1]),
    .ce_wdata_i(b_wdata[1]), .ce_rdata_o(o_rd[1]), .ce_ack_o(o_ack[1]),
    .spi_req_i(b_req[3]), .spi_we_i(b_we[3]), .spi_addr_i(b_addr[3]),
    .spi_wdata_i(b_wdata[3]), .spi_rdata_o(o_rd[3]), .spi_ack_o(o_ack[3]),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  typedef struct {
    int            per;
    int            lane;
    logic          ack;
    logic [DW-1:0] rd;
    int            acc;
    string         tag_ack;
    string         tag_rd;
  } item_t;

  item_t         q[$];
  int            total = 0, bad = 0, per_no = 0, acc_cnt = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_hold [4];

  function automatic logic [DW-1:0] word_init(int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (ram_en === 1'b1) acc_cnt++;

  // driver: one base period of requests, expected results pushed to the scoreboard
  task automatic drive_period(input logic [3:0] req, input logic [3:0] we,
                              input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                              input logic [AW-1:0] a2, input logic [AW-1:0] a3,
                              input string rtag);
    logic [AW-1:0] a [4];
    item_t it;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    @(posedge base_clk);
    #1;
    per_no++;
    for (int s = 0; s < 4; s++) begin
      b_req[s]   = req[s];
      b_we[s]    = we[s];
      b_addr[s]  = a[s];
      b_wdata[s] = $urandom();
    end
    for (int s = 0; s < 4; s++) begin
      if (req[s] && !we[s]) exp_hold[s] = ref_mem[a[s]];
      else if (req[s] && we[s]) ref_mem[a[s]] = b_wdata[s];
      it.per = per_no; it.lane = s; it.ack = req[s]; it.rd = exp_hold[s]; it.acc = 0;
      it.tag_ack = (s == 0 || s == 2) ? "R9 processor lane ack" : "R4 ack";
      it.tag_rd = (req[s] && we[s]) ? "R6 write keeps rdata" : rtag;
      q.push_back(it);
    end
    it.per = per_no; it.lane = 4; it.ack = 1'b0; it.rd = '0; it.acc = $countones(req);
    it.tag_ack = "R3 access count"; it.tag_rd = "";
    q.push_back(it);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      if (req[s]) begin
        chk("R2 slot route", {ram_en, ram_we, ram_addr}, {1'b1, we[s], a[s]});
        if (we[s]) chk("R10 write data", ram_wdata, b_wdata[s]);
      end else begin
        chk("R3 idle slot quiet", {ram_en, ram_we}, 2'b00);
      end
    end
  endtask

  // monitor: compare published results of the previous period
  initial begin
    item_t it;
    int snap;
    forever begin
      @(posedge base_clk);
      #3;
      snap = acc_cnt;
      acc_cnt = 0;
      while (q.size() > 0 && q[0].per < per_no) begin
        it = q.pop_front();
        if (it.lane == 4) chk(it.tag_ack, 64'(snap), 64'(it.acc));
        else begin
          chk(it.tag_ack, o_ack[it.lane], it.ack);
          chk(it.tag_rd, o_rd[it.lane], it.rd);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = word_init(i);
      ref_mem[i] = word_init(i);
    end
    for (int s = 0; s < 4; s++) begin
      b_addr[s] = '0; b_wdata[s] = '0; exp_hold[s] = '0;
    end
    b_req = '0; b_we = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset acks", o_ack, 4'h0);
    chk("R8 reset rdata", {o_rd[0] | o_rd[1] | o_rd[2] | o_rd[3]}, 0);
    chk("R8 reset base clock", base_clk, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    @(posedge base_clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R1 base clock phase", base_clk, (k % 4) < 2);
    end

    drive_period(4'hF, 4'h0, 9'd5, 9'd17, 9'd300, 9'd511, "R5 read all lanes");
    drive_period(4'hF, 4'hF, 9'd10, 9'd11, 9'd12, 9'd13, "R6");
    drive_period(4'hF, 4'h0, 9'd10, 9'd11, 9'd12, 9'd13, "R5 readback");
    drive_period(4'b1001, 4'b1001, 9'd40, 9'd0, 9'd0, 9'd40, "R6 collide");
    drive_period(4'b0001, 4'h0, 9'd40, 9'd0, 9'd0, 9'd0, "R7 later slot wins");
    drive_period(4'b0110, 4'b0110, 9'd0, 9'd60, 9'd60, 9'd0, "R6 collide b");
    drive_period(4'b1000, 4'h0, 9'd0, 9'd0, 9'd0, 9'd60, "R7 later slot wins b");
    drive_period(4'b0011, 4'b0001, 9'd50, 9'd50, 9'd0, 9'd0, "R5 same-period forward");
    drive_period(4'b0010, 4'h0, 9'd0, 9'd7, 9'd0, 9'd0, "R3 single lane");
    drive_period(4'b0000, 4'h0, 9'd1, 9'd2, 9'd3, 9'd4, "R6 idle hold");
    drive_period(4'b0100, 4'h0, 9'd0, 9'd0, 9'd511, 9'd0, "R9 lane B alone");
    drive_period(4'b0101, 4'b0100, 9'd0, 9'd0, 9'd511, 9'd0, "R9 lanes independent");
    drive_period(4'b0101, 4'h0, 9'd511, 9'd0, 9'd0, 9'd0, "R9 lane readback");

    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] ra [4];
      for (int s = 0; s < 4; s++)
        ra[s] = ($urandom_range(0, 8) == 8) ? 9'd511 : 9'($urandom_range(0, 7));
      drive_period(4'($urandom()), 4'($urandom()), ra[0], ra[1], ra[2], ra[3],
                   "R5 random traffic");
    end

    drive_period(4'h0, 4'h0, 9'd0, 9'd0, 9'd0, 9'd0, "R6 final idle");
    @(posedge base_clk);
    #5;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule